// File: doc/BRIEF.md
# Status Flag Generator and Branch Condition Evaluator

This block is the flag half of an integer execution unit. It takes an operation code, an operand size and two operands. It forms the result of an add, subtract, compare, bitwise-AND test, increment or decrement, and it computes carry, parity, zero, sign and overflow for that operation. The datapath is 32 bits wide. An operation can be narrowed to its low 8 or 16 bits, and all flags then come from that narrowed width. A write-enable tells the register file whether the result belongs in the destination. Compare and test change only the flags.

In the same cycle, a 4-bit condition selector is evaluated against the flag register the block receives as an input. The outcome is a taken bit for the branch unit. Conditions are provided for unsigned ordering, signed ordering and each single flag, and every condition has its complement next to it.

The block is purely combinational. The flag register, the program counter and the branch target lie outside it.

Top module: `flag_unit`

## Requirements
- R1: Operation codes are: 0 add, 1 subtract, 2 compare, 3 test, 4 increment, 5 decrement. Add produces `result_o` equal to (a+b) modulo 2^W, where W is the selected width, and zero above W. Carry is the carry out of bit W-1. Overflow is set when both operands have the same sign and the result's sign differs from it. `wr_en_o` is 1.
- R2: Subtract produces (a-b) modulo 2^W. Carry is set when a is below b as unsigned numbers. Overflow is set when the operand signs differ and the result's sign differs from a's sign. `wr_en_o` is 1.
- R3: Compare produces the same flags as subtract and drives `wr_en_o` to 0.
- R4: Increment produces a+1 and decrement produces a-1, both modulo 2^W, with `wr_en_o` at 1. Zero, sign, parity and overflow are updated, and carry is copied from `flags_i`.
- R5: Test forms a AND b and drives `wr_en_o` to 0. Carry and overflow are cleared. Zero is set exactly when no bit position within W is 1 in both operands.
- R6: Zero is set when the W-bit result is all zeros. Sign equals bit W-1 of the result.
- R7: Parity is set when bits 7..0 of the result hold an even number of ones, for every size.
- R8: `size_i` selects the width: 0 gives 8 bits, 1 gives 16, and 2 or 3 gives 32. Operand bits above W have no effect on any output.
- R9: The flag vector (`flags_i`, `flags_o`) is laid out as bit 0 carry, bit 1 parity, bit 2 zero, bit 3 sign, bit 4 overflow.
- R10: The unsigned conditions are evaluated on `flags_i`: code 2 below (C=1), 3 above-or-equal (C=0), 6 below-or-equal (C or Z), 7 above (C=0 and Z=0).
- R11: The signed conditions are: code 12 less (S xor O), 13 greater-or-equal (not that), 14 less-or-equal ((S xor O) or Z), 15 greater (neither).
- R12: The single-flag conditions are: code 0 overflow, 1 no overflow, 4 zero, 5 not zero, 8 sign, 9 no sign, 10 parity, 11 no parity. Each odd code is the complement of the even code below it.
- R13: Operation codes 6 and 7 drive `wr_en_o` to 0 and pass `flags_i` through to `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand width select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cond_i | input | 4 | Condition selector |
| flags_i | input | 5 | Current flag register |
| result_o | output | 32 | Operation result, zero above the selected width |
| wr_en_o | output | 1 | Result is to be written |
| flags_o | output | 5 | Updated flags |
| taken_o | output | 1 | Selected condition holds on flags_i |

## Verification
Some properties are checked by assertions on every evaluation:
- compare and test never raise the write-enable;
- increment and decrement hold the incoming carry;
- test clears carry and overflow;
- parity and zero agree with the result;
- the greater condition is never taken while zero is set.

Other behaviour is shown only by the bench's scenarios, which compare against an independent model:
- the arithmetic values themselves;
- carry and overflow at the 8-, 16- and 32-bit boundaries;
- that upper operand bits are ignored;
- the full table of 16 conditions.

// File: rtl/flagcalc_pkg.sv
package flagcalc_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_TST  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  // bit 0 carry ... bit 4 overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic par;
    logic cry;
  } flags_t;

endpackage

// File: rtl/flag_arith.sv
module flag_arith
  import flagcalc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cry_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            fl_o
);

  localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;
  localparam int SEL_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1;

  logic              is_sub, is_tst, is_step;
  logic [DATA_W-1:0] b_x;
  logic              cin;
  logic [SEL_W-1:0]  sel;

  logic [NUM_SIZES-1:0][DATA_W-1:0] res_v;
  logic [NUM_SIZES-1:0]             cout_v, ovf_v, zro_v, sgn_v;

  assign is_sub  = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign is_tst  = (op_i == OP_TST);
  assign is_step = (op_i == OP_INC) || (op_i == OP_DEC);

  always_comb begin
    b_x = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin b_x = ~b_i; cin = 1'b1; end
      OP_INC:         begin b_x = '0;   cin = 1'b1; end
      OP_DEC:         begin b_x = '1;   cin = 1'b0; end
      default:        ;
    endcase
  end

  assign sel = (32'(size_i) >= NUM_SIZES) ? SEL_W'(NUM_SIZES - 1) : SEL_W'(size_i);

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_sz
    localparam int W = 8 << i;
    logic [W:0] raw;
    always_comb begin
      if (is_tst) raw = {1'b0, a_i[W-1:0] & b_i[W-1:0]};
      else        raw = {1'b0, a_i[W-1:0]} + {1'b0, b_x[W-1:0]} + {{W{1'b0}}, cin};
    end
    assign res_v[i]  = DATA_W'(raw[W-1:0]);
    assign cout_v[i] = raw[W];
    assign zro_v[i]  = ~|raw[W-1:0];
    assign sgn_v[i]  = raw[W-1];
    assign ovf_v[i]  = (a_i[W-1] == b_x[W-1]) && (raw[W-1] != a_i[W-1]);
  end

  assign res_o = res_v[sel];

  always_comb begin
    fl_o.zro = zro_v[sel];
    fl_o.sgn = sgn_v[sel];
    fl_o.par = ~^res_o[7:0];
    fl_o.ovf = is_tst ? 1'b0 : ovf_v[sel];
    if (is_tst)       fl_o.cry = 1'b0;
    else if (is_step) fl_o.cry = cry_i;
    else if (is_sub)  fl_o.cry = ~cout_v[sel];
    else              fl_o.cry = cout_v[sel];
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, size_i})) begin
      assert_tst_clears_R5: assert (!is_tst || (!fl_o.cry && !fl_o.ovf))
        else $error("test left carry/overflow set");
      assert_parity_low_byte_R7: assert (fl_o.par == ((($countones(res_o[7:0])) % 2) == 0))
        else $error("parity mismatch");
      assert_zero_matches_R6: assert (!fl_o.zro || (res_o == '0))
        else $error("zero set on nonzero result");
    end
  end

endmodule

// File: rtl/flag_cond.sv
module flag_cond
  import flagcalc_pkg::*;
(
  input  flags_t     fl_i,
  input  logic [3:0] cond_i,
  output logic       taken_o
);

  logic       lt;
  logic [7:0] base;

  assign lt = fl_i.sgn ^ fl_i.ovf;

  // even code = base test, odd code = its complement
  always_comb begin
    base[0] = fl_i.ovf;
    base[1] = fl_i.cry;
    base[2] = fl_i.zro;
    base[3] = fl_i.cry | fl_i.zro;
    base[4] = fl_i.sgn;
    base[5] = fl_i.par;
    base[6] = lt;
    base[7] = lt | fl_i.zro;
  end

  assign taken_o = base[cond_i[3:1]] ^ cond_i[0];

  always_comb begin
    if (!$isunknown({fl_i, cond_i})) begin
      assert_greater_not_zero_R11: assert (!(cond_i == 4'd15 && taken_o) || !fl_i.zro)
        else $error("greater taken with zero set");
      assert_above_clear_R10: assert (!(cond_i == 4'd7 && taken_o) || (!fl_i.cry && !fl_i.zro))
        else $error("above taken with carry or zero");
    end
  end

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flagcalc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        cond_i,
  input  logic [4:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [4:0]        flags_o,
  output logic              taken_o
);

  op_e    op;
  flags_t fl_in, fl_new;
  logic   op_valid;

  assign op       = op_e'(op_i);
  assign fl_in    = flags_t'(flags_i);
  assign op_valid = (op != OP_RSV6) && (op != OP_RSV7);

  flag_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i   (op),
    .size_i (size_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .cry_i  (fl_in.cry),
    .res_o  (result_o),
    .fl_o   (fl_new)
  );

  flag_cond u_cond (
    .fl_i    (fl_in),
    .cond_i  (cond_i),
    .taken_o (taken_o)
  );

  assign wr_en_o = (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
  assign flags_o = op_valid ? fl_new : flags_i;

  always_comb begin
    if (!$isunknown({op_i, flags_i, a_i, b_i, size_i})) begin
      assert_no_write_R3: assert (!((op == OP_CMP) || (op == OP_TST)) || !wr_en_o)
        else $error("flag-only op wrote result");
      assert_carry_hold_R4: assert (!((op == OP_INC) || (op == OP_DEC)) || (flags_o[0] == flags_i[0]))
        else $error("inc/dec altered carry");
      assert_reserved_pass_R13: assert (op_valid || (!wr_en_o && flags_o == flags_i))
        else $error("reserved op changed state");
    end
  end

endmodule

// File: tb/sim_flag_unit.sv
module sim_flag_unit;

  logic        clk = 1'b0;
  logic [2:0]  op;
  logic [1:0]  sz;
  logic [31:0] a, b;
  logic [3:0]  cc;
  logic [4:0]  fi;
  logic [31:0] res;
  logic        wr;
  logic [4:0]  fo;
  logic        tk;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flag_unit u0 (
    .op_i(op), .size_i(sz), .a_i(a), .b_i(b), .cond_i(cc), .flags_i(fi),
    .result_o(res), .wr_en_o(wr), .flags_o(fo), .taken_o(tk)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (op=%0d sz=%0d a=%h b=%h cc=%0d fi=%b)",
               tag, act, exp, op, sz, a, b, cc, fi);
    end
  endtask

  function automatic longint sext(input longint v, input int w);
    return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
  endfunction

  function automatic void model(input logic [2:0] o, input logic [1:0] s, input logic [31:0] x, input logic [31:0] y,
                                input logic [4:0] f, output logic [31:0] r, output logic [4:0] fl, output logic w);
    int W;
    longint m, ua, ub, full, sa, sb, sr, lo, hi;
    logic c, v, z, sg, p;
    W  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m  = (longint'(1) << W) - 1;
    ua = longint'(x) & m;
    ub = longint'(y) & m;
    sa = sext(ua, W);
    sb = sext(ub, W);
    lo = -(longint'(1) << (W - 1));
    hi = (longint'(1) << (W - 1)) - 1;
    c = 1'b0; sr = 0; full = 0;
    case (o)
      3'd0: begin full = ua + ub; c = full[W]; sr = sa + sb; end
      3'd1, 3'd2: begin full = ua - ub; c = (ua < ub); sr = sa - sb; end
      3'd3: begin full = ua & ub; c = 1'b0; sr = 0; end
      3'd4: begin full = ua + 1; c = f[0]; sr = sa + 1; end
      3'd5: begin full = ua - 1; c = f[0]; sr = sa - 1; end
      default: ;
    endcase
    full = full & m;
    r  = full[31:0];
    v  = (sr < lo) || (sr > hi);
    z  = (full == 0);
    sg = full[W-1];
    p  = ~^r[7:0];
    w  = (o == 3'd0) || (o == 3'd1) || (o == 3'd4) || (o == 3'd5);
    if (o >= 3'd6) begin fl = f; r = '0; end
    else fl = {v, sg, z, p, c};
  endfunction

  function automatic logic cond_model(input logic [3:0] k, input logic [4:0] f);
    logic c, p, z, s, v;
    {v, s, z, p, c} = f;
    case (k)
      4'd0: return v;         4'd1: return !v;
      4'd2: return c;         4'd3: return !c;
      4'd4: return z;         4'd5: return !z;
      4'd6: return c | z;     4'd7: return !c & !z;
      4'd8: return s;         4'd9: return !s;
      4'd10: return p;        4'd11: return !p;
      4'd12: return s != v;   4'd13: return s == v;
      4'd14: return (s != v) | z;
      default: return (s == v) & !z;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1 add";
      3'd1: return "R2 sub";
      3'd2: return "R3 cmp";
      3'd3: return "R5 test";
      3'd4, 3'd5: return "R4 inc/dec";
      default: return "R13 reserved";
    endcase
  endfunction

  function automatic string cc_tag(input logic [3:0] k);
    if (k >= 4'd12) return "R11 signed cond";
    if (k == 4'd2 || k == 4'd3 || k == 4'd6 || k == 4'd7) return "R10 unsigned cond";
    return "R12 flag cond";
  endfunction

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [31:0] x, input logic [31:0] y,
                       input logic [3:0] k, input logic [4:0] f, input string note);
    logic [31:0] er;
    logic [4:0]  ef;
    logic        ew;
    @(posedge clk);
    op = o; sz = s; a = x; b = y; cc = k; fi = f;
    @(negedge clk);
    model(o, s, x, y, f, er, ef, ew);
    chk(wr == ew, {op_tag(o), " wr_en ", note}, 32'(wr), 32'(ew));
    chk(fo == ef, {op_tag(o), " flags R6 R7 R9 ", note}, 32'(fo), 32'(ef));
    if (ew) chk(res == er, {op_tag(o), " result R8 ", note}, res, er);
    chk(tk == cond_model(k, f), {cc_tag(k), " ", note}, 32'(tk), 32'(cond_model(k, f)));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    op = '0; sz = '0; a = '0; b = '0; cc = '0; fi = '0;
    @(negedge clk);
    // initial state: 0+0 on 8 bits gives zero with Z and P set
    chk(res == 32'd0 && wr && fo == 5'b00110, "R1 initial", {26'd0, wr, fo}, {26'd0, 1'b1, 5'b00110});

    apply(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 4'd2, 5'b00000, "8b carry wrap R1");
    apply(3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 4'd0, 5'b10000, "8b overflow R1");
    apply(3'd0, 2'd0, 32'hABCD_12FF, 32'hFFFF_FF01, 4'd4, 5'b00100, "upper bits ignored R8");
    apply(3'd0, 2'd3, 32'hFFFF_FFFF, 32'h0000_0001, 4'd5, 5'b00000, "size 3 as 32 R8");
    apply(3'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 4'd12, 5'b01000, "32b sub overflow R2");
    apply(3'd1, 2'd1, 32'h0000_0003, 32'h0000_0005, 4'd6, 5'b00001, "16b borrow R2");
    apply(3'd2, 2'd2, 32'd5, 32'd7, 4'd13, 5'b11000, "compare below R3");
    apply(3'd2, 2'd0, 32'h0000_0042, 32'h0000_0042, 4'd15, 5'b00100, "compare equal R3");
    apply(3'd3, 2'd0, 32'h0000_00F0, 32'h0000_000F, 4'd9, 5'b10001, "test disjoint R5");
    apply(3'd3, 2'd2, 32'h8000_0001, 32'h8000_0000, 4'd8, 5'b00000, "test sign R5");
    apply(3'd4, 2'd1, 32'h0000_FFFF, 32'h0, 4'd3, 5'b00000, "inc wrap keeps carry 0 R4");
    apply(3'd5, 2'd0, 32'h0000_0000, 32'h0, 4'd2, 5'b00001, "dec wrap keeps carry 1 R4");
    apply(3'd5, 2'd0, 32'h0000_0080, 32'h0, 4'd1, 5'b00000, "dec overflow R4");
    apply(3'd0, 2'd2, 32'h0000_0103, 32'h0, 4'd10, 5'b00010, "parity low byte R7");
    apply(3'd6, 2'd2, 32'h1234_5678, 32'h1, 4'd11, 5'b10101, "reserved 6 R13");
    apply(3'd7, 2'd0, 32'hFF, 32'hFF, 4'd14, 5'b01010, "reserved 7 R13");

    // every condition code against every flag pattern: R10 R11 R12
    for (int k = 0; k < 16; k++)
      for (int f = 0; f < 32; f++)
        apply(3'd3, 2'd2, 32'h0, 32'h0, 4'(k), 5'(f), "cond sweep");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      int mode;
      mode = $urandom_range(0, 3);
      x = $urandom();
      y = $urandom();
      if (mode == 1) begin x = {$urandom_range(0, 1) ? 24'hFFFFFF : 24'h0, x[7:0]}; y = y & 32'hFF; end
      if (mode == 2) begin x = x ^ 32'h8000_8080; y = x; end
      apply(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), x, y,
            4'($urandom_range(0, 15)), 5'($urandom_range(0, 31)), "random");
    end

    summary();
    $finish;
  end

endmodule